// File: doc/BRIEF.md
# Direct-Mapped Branch Target Cache

This block sits in the fetch stage and predicts the next fetch address. A direct-mapped table remembers simple branches that were seen to resolve taken, with the full address of each branch and where it went. Each cycle the fetch stage presents the address it is fetching. When that address matches a live entry, the block raises a predicted-taken flag and gives the stored target, so the fetch stage can jump there on the next cycle and tag the instruction as predicted-taken. When there is no match the flag stays low, and the instruction goes on untagged so that static prediction further down the pipe still applies.

The execute stage sends an update for every resolved simple branch. An update always rewrites the entry at the branch's index with the branch address and target. It marks the entry live for a taken branch and dead for a not-taken one. To keep the table read off the compare path, the lookup is started two fetches early, from the current fetch address plus 8. This means a prediction is only possible from the third sequential fetch after any change of flow. A change of flow is a redirect from outside or a prediction made by the block itself.

Top module: `btc_predictor`

## Requirements
- R1: After reset every entry is dead, so `predTaken` stays 0 for any fetch sequence until a taken update has been written.
- R2: After a taken update for branch address P with target T, a fetch of P that has at least two prior sequential fetches (step 4 bytes, no change of flow) gives `predTaken`=1 in that same cycle with `predTarget`=T. Without a hit `predTaken` is 0.
- R3: A not-taken update for P makes the entry at P's index dead, so a later fetch of P gives `predTaken`=0.
- R4: A hit needs the whole stored branch address (bits 31:2) to equal the fetch address. A fetch that only shares the index (bits 11:2) gives no prediction.
- R5: In a cycle with `redirect`=1, and in the cycle right after it, `predTaken` is 0. The third fetch counting the redirect target as the first can be predicted.
- R6: A prediction counts as a change of flow. In the two cycles after `predTaken`=1, `predTaken` is 0, and the fetch after the target can't be predicted.
- R7: An update that writes the index being looked up in the same cycle (the index of fetch address + 8) is not seen by that lookup, which returns the old contents.
- R8: The table has 1024 entries indexed by fetch address bits 11:2. Entries at index 0 and index 1023 work independently of each other and of other entries.
- R9: A later update for the same branch replaces the stored target, and later hits give the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchAddr | input | 32 | Address fetched this cycle |
| redirect | input | 1 | This cycle's fetch address is a non-sequential target |
| updValid | input | 1 | Resolved simple branch update present |
| updTaken | input | 1 | Update branch was taken |
| updPc | input | 32 | Update branch address |
| updTarget | input | 32 | Update branch target |
| predTaken | output | 1 | Current fetch hit a live entry; jump next cycle |
| predTarget | output | 32 | Stored target, meaningful when predTaken is 1 |

## Verification
`predTaken` and `predTarget` depend combinationally on the current `fetchAddr` and `redirect`. They also depend on the table snapshot taken two clock edges earlier, when the lookup for that address started. Updates change the table at the edge that ends their cycle, so they are only seen by lookups started after that edge. The reference model keeps the last two snapshots and the last two redirect and prediction flags in plain variables. Inputs are driven after a falling edge, and the outputs for that fetch are compared 1 ns later, before the next rising edge. The model then shifts its history at the edge, so each cycle's expected result accounts for exactly the two edges between lookup and use.

// File: rtl/btc_pkg.sv
package btc_pkg;
  // strobes from control to the table datapath
  typedef struct packed {
    logic wrEn;     // write entry at update index
    logic wrLive;   // value for the entry's valid bit
  } btcStrobe_t;
endpackage

// File: rtl/btc_store.sv
module btc_store
  import btc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 10,
  parameter int LOOKAHEAD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  btcStrobe_t        strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              tagHit,
  output logic [ADDR_W-1:0] predTarget
);
  localparam int TAG_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] pcMem  [DEPTH];
  logic [TAG_W-1:0] tgtMem [DEPTH];
  logic [DEPTH-1:0] liveBits;

  logic [ADDR_W-1:0] lookAddr;
  logic [IDX_W-1:0]  lookIdx;
  logic [IDX_W-1:0]  updIdx;

  assign lookAddr = fetchAddr + ADDR_W'(LOOKAHEAD);
  assign lookIdx  = lookAddr[IDX_W+1:2];
  assign updIdx   = updPc[IDX_W+1:2];

  // table contents, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      pcMem[updIdx]  <= updPc[ADDR_W-1:2];
      tgtMem[updIdx] <= updTarget[ADDR_W-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) liveBits <= '0;
    else if (strobe.wrEn) liveBits[updIdx] <= strobe.wrLive;
  end

  // two-stage read pipe: stage one is read this edge, stage two is compared
  logic [TAG_W-1:0] s1Pc, s1Tgt, s2Pc, s2Tgt;
  logic             s1Live, s2Live;

  always_ff @(posedge clk) begin
    s1Pc  <= pcMem[lookIdx];
    s1Tgt <= tgtMem[lookIdx];
    s2Pc  <= s1Pc;
    s2Tgt <= s1Tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Live <= 1'b0;
      s2Live <= 1'b0;
    end else begin
      s1Live <= liveBits[lookIdx];
      s2Live <= s1Live;
    end
  end

  assign tagHit     = s2Live && (s2Pc == fetchAddr[ADDR_W-1:2]);
  assign predTarget = {s2Tgt, 2'b00};

  // R1: the first lookup out of reset sees a cleared table
  p_live_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst, 2) |-> !s2Live);
endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
  import btc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       redirect,
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       tagHit,
  output btcStrobe_t strobe,
  output logic       predTaken
);
  // s1Ok: lookup started last cycle lies on the current path
  // s2Ok: lookup being compared now lies on the current path
  logic s1Ok, s2Ok;

  assign predTaken = s2Ok && tagHit && !redirect;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Ok <= 1'b0;
      s2Ok <= 1'b0;
    end else begin
      s1Ok <= !predTaken;
      s2Ok <= s1Ok && !redirect && !predTaken;
    end
  end

  always_comb begin
    strobe.wrEn   = updValid;
    strobe.wrLive = updTaken;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !predTaken);
  p_redirect_now_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !predTaken);
  p_redirect_next_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !predTaken);
  p_hit_next_r6: assert property (@(posedge clk) disable iff (rst)
    predTaken |=> !predTaken);
  p_hit_second_r6: assert property (@(posedge clk) disable iff (rst)
    $past(predTaken, 2) |-> !predTaken);
endmodule

// File: rtl/btc_predictor.sv
module btc_predictor
  import btc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 10,
  parameter int LOOKAHEAD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              redirect,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predTarget
);
  btcStrobe_t strobe;
  logic       tagHit;

  btc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .redirect(redirect),
    .updValid(updValid), .updTaken(updTaken),
    .tagHit(tagHit), .strobe(strobe), .predTaken(predTaken)
  );

  btc_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOOKAHEAD(LOOKAHEAD)) u_store (
    .clk(clk), .rst(rst), .strobe(strobe), .fetchAddr(fetchAddr),
    .updPc(updPc), .updTarget(updTarget),
    .tagHit(tagHit), .predTarget(predTarget)
  );
endmodule

// File: tb/btc_predictor_test.sv
module btc_predictor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchAddr = '0;
  logic        redirect = 1'b0;
  logic        updValid = 1'b0;
  logic        updTaken = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic        predTaken;
  logic [31:0] predTarget;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  btc_predictor uut (
    .clk(clk), .rst(rst), .fetchAddr(fetchAddr), .redirect(redirect),
    .updValid(updValid), .updTaken(updTaken), .updPc(updPc),
    .updTarget(updTarget), .predTaken(predTaken), .predTarget(predTarget)
  );

  // reference model: table plus two-deep history of lookup snapshots
  bit          mLive [1024];
  logic [29:0] mPc   [1024];
  logic [29:0] mTgt  [1024];
  bit          h1Live, h2Live, r1, p1, p2;
  logic [29:0] h1Pc, h2Pc, h1Tgt, h2Tgt;
  int          cyc = 0;
  bit          lastPred;
  logic [31:0] lastTgt;
  logic [31:0] curAddr;

  function automatic int idxOf(input logic [31:0] a);
    return int'(a[11:2]);
  endfunction

  task automatic check(input string req, input bit ok, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(input bit redir, input logic [31:0] addr,
                      input bit uv, input bit ut,
                      input logic [31:0] upc, input logic [31:0] utg);
    bit expP;
    logic [31:0] expT;
    int li;
    redirect = redir; fetchAddr = addr;
    updValid = uv; updTaken = ut; updPc = upc; updTarget = utg;
    #1;
    expP = (cyc >= 2) && !redir && !r1 && !p1 && !p2 && h2Live && (h2Pc == addr[31:2]);
    expT = {h2Tgt, 2'b00};
    check(curReq, (predTaken == expP) && (!expP || predTarget == expT),
          $sformatf("addr=%h predTaken/predTarget actual=%b/%h expected=%b/%h",
                    addr, predTaken, predTarget, expP, expT));
    lastPred = expP; lastTgt = expT;
    // model edge: shift history, snapshot before update, then update
    li = idxOf(addr + 32'd8);
    h2Live = h1Live; h2Pc = h1Pc; h2Tgt = h1Tgt; p2 = p1;
    h1Live = mLive[li]; h1Pc = mPc[li]; h1Tgt = mTgt[li];
    r1 = redir; p1 = expP;
    if (uv) begin
      mLive[idxOf(upc)] = ut;
      mPc[idxOf(upc)]   = upc[31:2];
      mTgt[idxOf(upc)]  = utg[31:2];
    end
    cyc++;
    @(negedge clk);
    curAddr = lastPred ? lastTgt : addr + 32'd4;
  endtask

  task automatic runFrom(input logic [31:0] start, input int n);
    step(1'b1, start, 1'b0, 1'b0, '0, '0);
    for (int i = 1; i < n; i++) step(1'b0, curAddr, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt, input bit taken);
    step(1'b0, curAddr, 1'b1, taken, pc, tgt);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mLive[i] = 0; mPc[i] = '0; mTgt[i] = '0; end
    h1Live = 0; h2Live = 0; r1 = 0; p1 = 0; p2 = 0;
    h1Pc = '0; h2Pc = '0; h1Tgt = '0; h2Tgt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", predTaken == 1'b0,
          $sformatf("in reset predTaken actual=%b expected=0", predTaken));
    rst = 1'b0;
    // R1: empty table never predicts
    curReq = "R1";
    step(1'b0, 32'h1000, 1'b0, 1'b0, '0, '0);
    for (int i = 0; i < 10; i++) step(1'b0, curAddr, 1'b0, 1'b0, '0, '0);
    // R2: taken entry predicts on the third sequential fetch onward
    curReq = "R2";
    upd(32'h1010, 32'h2000, 1'b1);
    runFrom(32'h1000, 10);
    // R6: prediction is a change of flow for the next two fetches
    curReq = "R6";
    upd(32'h2008, 32'h2100, 1'b1);
    upd(32'h2104, 32'h7000, 1'b1);
    upd(32'h2108, 32'h4000, 1'b1);
    runFrom(32'h2000, 10);
    // R3: not-taken update kills the entry
    curReq = "R3";
    upd(32'h1010, 32'h2000, 1'b0);
    runFrom(32'h1000, 8);
    // R4: same index, different upper address bits
    curReq = "R4";
    upd(32'h5010, 32'h3000, 1'b1);
    runFrom(32'h1000, 8);
    // R5: redirect onto or just before the branch gives no prediction
    curReq = "R5";
    runFrom(32'h5010, 3);
    runFrom(32'h500C, 3);
    runFrom(32'h5008, 4);
    // R7: update to the index being read this cycle is not seen
    curReq = "R7";
    step(1'b1, 32'h6000, 1'b0, 1'b0, '0, '0);
    step(1'b0, 32'h6004, 1'b1, 1'b1, 32'h600C, 32'h6800);
    step(1'b0, 32'h6008, 1'b0, 1'b0, '0, '0);
    step(1'b0, 32'h600C, 1'b0, 1'b0, '0, '0);
    runFrom(32'h6000, 5);
    // R8: boundary indices 0 and 1023
    curReq = "R8";
    upd(32'h0FFC, 32'h8000, 1'b1);
    upd(32'h9000, 32'h8800, 1'b1);
    runFrom(32'h0FF4, 4);
    runFrom(32'h8FF8, 5);
    runFrom(32'h5008, 4);
    // R9: later update replaces the target
    curReq = "R9";
    upd(32'h5010, 32'h3400, 1'b1);
    runFrom(32'h5008, 5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule